// File: doc/BRIEF.md
# Two-rank crosspoint configuration register

This block is the digital control front end of a small video crosspoint switch. It holds one routing entry per output and drives a select and an enable for each output's input multiplexer. Configuration arrives over one of two interfaces, chosen by a mode pin. In serial mode, a write strobe clocks a bit stream through a chain, and a registered cascade output lets several devices be daisy-chained. In parallel mode, each write strobe delivers one output address and one 4-bit function code.

Written data first lands in a staging rank. A second rank, which drives the outputs, copies it in one of several ways. In edge mode it copies on a rising latch edge. In level mode it follows the staging rank while the latch is low. Some function codes force the copy, and a software-latch code also forces it while the latch is held high.

The write and latch strobes are asynchronous to the system clock. They pass through a synchroniser and an edge detector, so each action takes effect on the third clock edge after the strobe rises.

Top module: `xpt_cfg_top`

## Requirements
- R1: After an active-low reset, every output is disabled with select 0, both ranks hold that state, and the serial output is 0.
- R2: With the mode pin high, each rising write strobe shifts data bit 0 into the staging chain. Output k's entry occupies chain bits 4k+3..4k, so output 0's field arrives last. Each entry is bit 3 = disable (1 = off) and bits 2..0 = input number, sent most significant bit first.
- R3: In serial mode the serial output is registered. After every shift it shows the bit pushed out of the chain's top (bit 31), and it holds between shifts.
- R4: With the mode pin low, codes 0000 to 0111 load the addressed staging entry with that input number and clear its disable bit.
- R5: With the edge/level select high, the output rank copies the staging rank only on a rising latch. It keeps its value while the latch stays high, stays low, or falls.
- R6: With the edge/level select low, the output rank follows the staging rank while the latch is low and holds while it is high.
- R7: Code 1011 sets the disable bit of the addressed entry and copies the staging rank, including this change, into the output rank.
- R8: Code 1100 sets every disable bit and copies the result into the output rank.
- R9: Codes 1101 and 1110 leave the staging rank unchanged and copy it into the output rank.
- R10: Code 1111 copies the staging rank into the output rank when the latch is high. With the latch low in edge mode, it does nothing.
- R11: Codes 1000, 1001 and 1010 change neither rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serMode | input | 1 | 1 = serial interface, 0 = parallel interface |
| edgeMode | input | 1 | 1 = output rank loads on rising latch, 0 = transparent while latch low |
| wrStrobe | input | 1 | Asynchronous write strobe, acts on its rising edge |
| latchIn | input | 1 | Asynchronous latch control |
| dataIn | input | 4 | Function code in parallel mode; bit 0 is serial data in serial mode |
| addr | input | 3 | Output address in parallel mode |
| serOut | output | 1 | Registered cascade output (bit leaving the chain) |
| serOutEn | output | 1 | High when the shared data-1 pin acts as the cascade output |
| selOut | output | 24 | Per-output input select, 3 bits per output, output 0 in bits 2..0 |
| enOut | output | 8 | Per-output enable, bit k for output k |

## Verification
The staging rank has no port of its own. A corrupted staging entry stays hidden until the next transfer, which copies it onto selOut/enOut a few cycles after a latch or forcing code. In level mode with the latch low, it appears about three cycles after the write. A fault in the output rank or its transfer logic shows on selOut/enOut at once, as a missing, early or stray update. A fault in the shift path shows on serOut only once the bad bit reaches the top of the 32-bit chain, so the bench keeps shifting past a full chain length. Mixed random stimulus compares every output after each operation against a bench model of both ranks.

// File: rtl/xpt_cfg_pkg.sv
`timescale 1ns/1ps
package xpt_cfg_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_DIS_ONE  = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_DIS_ALL  = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_XFER_A   = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_XFER_B   = 4'b1110;
  localparam logic [CODE_W-1:0] CODE_SOFT_LAT = 4'b1111;

  // Single-cycle commands from control to datapath
  typedef struct packed {
    logic shift;   // serial shift of staging chain
    logic route;   // load addressed entry with input number, enable
    logic disOne;  // set disable bit of addressed entry
    logic disAll;  // set all disable bits
    logic xfer;    // copy staging next-state into output rank
  } xptStrobe_t;

endpackage

// File: rtl/xpt_cfg_ctrl.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl
  import xpt_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serMode,
  input  logic              edgeMode,
  input  logic              wrStrobe,
  input  logic              latchIn,
  input  logic [CODE_W-1:0] code,
  output xptStrobe_t        strb
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] wrSync, latchSync;
  logic         wrPrev, latchPrev;
  logic         wrRise, latchRise, latchHigh;
  logic         parWr, codeXfer, softXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync    <= '0;
      latchSync <= '0;
      wrPrev    <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      wrSync    <= {wrSync[TOP-1:0], wrStrobe};
      latchSync <= {latchSync[TOP-1:0], latchIn};
      wrPrev    <= wrSync[TOP];
      latchPrev <= latchSync[TOP];
    end
  end

  assign latchHigh = latchSync[TOP];
  assign wrRise    = wrSync[TOP] & ~wrPrev;
  assign latchRise = latchHigh & ~latchPrev;

  assign parWr    = wrRise & ~serMode;
  assign codeXfer = parWr & (code >= CODE_DIS_ONE) & (code <= CODE_XFER_B);
  assign softXfer = parWr & (code == CODE_SOFT_LAT) & latchHigh;

  always_comb begin
    strb        = '0;
    strb.shift  = wrRise & serMode;
    strb.route  = parWr & ~code[CODE_W-1];
    strb.disOne = parWr & (code == CODE_DIS_ONE);
    strb.disAll = parWr & (code == CODE_DIS_ALL);
    strb.xfer   = codeXfer | softXfer
                | (edgeMode & latchRise)
                | (~edgeMode & ~latchHigh);
  end

  // R2: an edge-detected write is a single-cycle pulse
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrRise |=> !wrRise);

  // R4: at most one staging-rank operation per cycle
  p_ops_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shift, strb.route, strb.disOne, strb.disAll}));

  // R10: soft latch with latch low in edge mode must not transfer
  p_soft_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (parWr && code == CODE_SOFT_LAT && !latchHigh && edgeMode) |-> !strb.xfer);

endmodule

// File: rtl/xpt_cfg_datapath.sv
`timescale 1ns/1ps
module xpt_cfg_datapath
  import xpt_cfg_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xptStrobe_t               strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CODE_W-1:0]        code,
  input  logic                     serIn,
  output logic                     serOut,
  output logic [NUM_OUT*SEL_W-1:0] selOut,
  output logic [NUM_OUT-1:0]       enOut
);

  localparam int FIELD_W = SEL_W + 1;
  localparam int CHAIN_W = NUM_OUT * FIELD_W;
  localparam logic [FIELD_W-1:0] OFF_ENTRY = {1'b1, {SEL_W{1'b0}}};
  localparam logic [CHAIN_W-1:0] RESET_VAL = {NUM_OUT{OFF_ENTRY}};

  logic [CHAIN_W-1:0] rank1, rank1Next, rank2;
  logic               serOutQ;

  always_comb begin
    rank1Next = rank1;
    if (strb.shift) begin
      rank1Next = {rank1[CHAIN_W-2:0], serIn};
    end else if (strb.route) begin
      rank1Next[int'(addr)*FIELD_W +: FIELD_W] = {1'b0, code[SEL_W-1:0]};
    end else if (strb.disOne) begin
      rank1Next[int'(addr)*FIELD_W + SEL_W] = 1'b1;
    end else if (strb.disAll) begin
      for (int i = 0; i < NUM_OUT; i++) rank1Next[i*FIELD_W + SEL_W] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rank1   <= RESET_VAL;
      rank2   <= RESET_VAL;
      serOutQ <= 1'b0;
    end else begin
      rank1 <= rank1Next;
      if (strb.xfer)  rank2   <= rank1Next;
      if (strb.shift) serOutQ <= rank1[CHAIN_W-1];
    end
  end

  assign serOut = serOutQ;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign selOut[k*SEL_W +: SEL_W] = rank2[k*FIELD_W +: SEL_W];
    assign enOut[k]                 = ~rank2[k*FIELD_W + SEL_W];
  end

  // R11: staging rank holds when no operation is strobed
  p_rank1_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shift || strb.route || strb.disOne || strb.disAll) |=> $stable(rank1));

  // R5: output rank holds without a transfer
  p_rank2_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xfer |=> $stable(rank2));

  // R6: after a transfer both ranks agree
  p_rank2_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> (rank2 == rank1));

  // R3: cascade output carries the bit that left the chain
  p_serout_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (serOutQ == $past(rank1[CHAIN_W-1])));

  // R3: cascade output holds between shifts
  p_serout_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(serOutQ));

endmodule

// File: rtl/xpt_cfg_top.sv
`timescale 1ns/1ps
module xpt_cfg_top
  import xpt_cfg_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int NUM_IN      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_IN),
  parameter int ADDR_W      = $clog2(NUM_OUT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serMode,
  input  logic                     edgeMode,
  input  logic                     wrStrobe,
  input  logic                     latchIn,
  input  logic [CODE_W-1:0]        dataIn,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     serOut,
  output logic                     serOutEn,
  output logic [NUM_OUT*SEL_W-1:0] selOut,
  output logic [NUM_OUT-1:0]       enOut
);

  xptStrobe_t strb;

  xpt_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serMode  (serMode),
    .edgeMode (edgeMode),
    .wrStrobe (wrStrobe),
    .latchIn  (latchIn),
    .code     (dataIn),
    .strb     (strb)
  );

  xpt_cfg_datapath #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .code   (dataIn),
    .serIn  (dataIn[0]),
    .serOut (serOut),
    .selOut (selOut),
    .enOut  (enOut)
  );

  assign serOutEn = serMode;

endmodule

// File: tb/tb_xpt_cfg_top.sv
`timescale 1ns/1ps
module tb_xpt_cfg_top;

  logic        clk = 1'b0;
  logic        rstN, serMode, edgeMode, wrStrobe, latchIn;
  logic [3:0]  dataIn;
  logic [2:0]  addr;
  logic        serOut, serOutEn;
  logic [23:0] selOut;
  logic [7:0]  enOut;

  logic [31:0] m1, m2;
  logic        mSer, mLatch;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  xpt_cfg_top dut (
    .clk(clk), .rstN(rstN), .serMode(serMode), .edgeMode(edgeMode),
    .wrStrobe(wrStrobe), .latchIn(latchIn), .dataIn(dataIn), .addr(addr),
    .serOut(serOut), .serOutEn(serOutEn), .selOut(selOut), .enOut(enOut)
  );

  function automatic logic [31:0] expObs(input logic [31:0] r);
    logic [31:0] o = '0;
    for (int i = 0; i < 8; i++) begin
      o[i*3 +: 3] = r[i*4 +: 3];
      o[24 + i]   = ~r[i*4 + 3];
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check({enOut, selOut} == expObs(m2), req, {enOut, selOut}, expObs(m2));
    check(serOut == mSer, req, {31'b0, serOut}, {31'b0, mSer});
  endtask

  task automatic settle();
    if (!edgeMode && !mLatch) m2 = m1;
  endtask

  task automatic pulseWr();
    wrStrobe = 1'b1;
    repeat (4) @(negedge clk);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic parWrite(input logic [3:0] c, input logic [2:0] a);
    logic [31:0] n;
    serMode = 1'b0; dataIn = c; addr = a;
    pulseWr();
    n = m1;
    if (!c[3]) n[a*4 +: 4] = {1'b0, c[2:0]};
    else if (c == 4'b1011) n[a*4 + 3] = 1'b1;
    else if (c == 4'b1100) for (int i = 0; i < 8; i++) n[i*4 + 3] = 1'b1;
    m1 = n;
    if (c >= 4'b1011 && c <= 4'b1110) m2 = m1;
    if (c == 4'b1111 && mLatch) m2 = m1;
    settle();
  endtask

  task automatic serialBit(input logic b);
    serMode = 1'b1; dataIn = {3'b0, b}; addr = 3'd0;
    pulseWr();
    mSer = m1[31];
    m1 = {m1[30:0], b};
    settle();
  endtask

  task automatic setLatch(input logic b);
    logic rise;
    rise = b & ~mLatch;
    latchIn = b;
    repeat (6) @(negedge clk);
    if (edgeMode && rise) m2 = m1;
    mLatch = b;
    settle();
  endtask

  task automatic setEdge(input logic b);
    edgeMode = b;
    repeat (2) @(negedge clk);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    void'($urandom(32'd20240611));
    rstN = 1'b0; serMode = 1'b0; edgeMode = 1'b1; wrStrobe = 1'b0;
    latchIn = 1'b0; dataIn = '0; addr = '0;
    m1 = {8{4'b1000}}; m2 = m1; mSer = 1'b0; mLatch = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(enOut == 8'h00, "R1", {24'b0, enOut}, 32'h0);
    check(selOut == 24'h0, "R1", {8'b0, selOut}, 32'h0);
    check(serOut == 1'b0, "R1", {31'b0, serOut}, 32'h0);

    // R4/R5 edge mode: staged write invisible until latch rises
    setEdge(1'b1);
    parWrite(4'b0101, 3'd2);
    check(enOut[2] == 1'b0, "R5", {31'b0, enOut[2]}, 32'h0);
    checkAll("R5");
    setLatch(1'b1);
    check(selOut[8:6] == 3'd5 && enOut[2], "R4", {28'b0, enOut[2], selOut[8:6]}, 32'hD);
    checkAll("R4");
    setLatch(1'b0);
    checkAll("R5");

    // R7 disable addressed output with forced transfer
    parWrite(4'b0011, 3'd4);
    parWrite(4'b1011, 3'd2);
    check(enOut[2] == 1'b0 && enOut[4], "R7", {30'b0, enOut[4], enOut[2]}, 32'h2);
    checkAll("R7");

    // R11 reserved codes ignored
    parWrite(4'b1000, 3'd4);
    parWrite(4'b1001, 3'd5);
    parWrite(4'b1010, 3'd6);
    setLatch(1'b1);
    setLatch(1'b0);
    check(enOut[4] && selOut[14:12] == 3'd3, "R11", {28'b0, enOut[4], selOut[14:12]}, 32'hB);
    checkAll("R11");

    // R9 transfer-only codes
    parWrite(4'b0111, 3'd1);
    parWrite(4'b1101, 3'd0);
    checkAll("R9");
    parWrite(4'b0001, 3'd3);
    parWrite(4'b1110, 3'd7);
    checkAll("R9");

    // R10 soft latch: no effect with latch low, transfers with latch high
    parWrite(4'b0110, 3'd6);
    parWrite(4'b1111, 3'd0);
    check(enOut[6] == 1'b0, "R10", {31'b0, enOut[6]}, 32'h0);
    checkAll("R10");
    setLatch(1'b1);
    parWrite(4'b0010, 3'd5);
    checkAll("R10");
    parWrite(4'b1111, 3'd0);
    check(enOut[5] && selOut[17:15] == 3'd2, "R10", {28'b0, enOut[5], selOut[17:15]}, 32'hA);
    checkAll("R10");
    setLatch(1'b0);

    // R8 disable all
    parWrite(4'b1100, 3'd0);
    check(enOut == 8'h00, "R8", {24'b0, enOut}, 32'h0);
    checkAll("R8");

    // R6 level mode
    setEdge(1'b0);
    parWrite(4'b0100, 3'd3);
    check(enOut[3] && selOut[11:9] == 3'd4, "R6", {28'b0, enOut[3], selOut[11:9]}, 32'hC);
    setLatch(1'b1);
    parWrite(4'b0000, 3'd3);
    checkAll("R6");
    setLatch(1'b0);
    checkAll("R6");

    // R2/R3 serial load of a full chain plus overflow
    setEdge(1'b1);
    pat = 32'h0A1B_C2D3;
    for (int k = 31; k >= 0; k--) begin
      serialBit(pat[k]);
      checkAll("R3");
    end
    setLatch(1'b1);
    check(enOut[0] == ~pat[3] && selOut[2:0] == pat[2:0], "R2",
          {28'b0, enOut[0], selOut[2:0]}, {28'b0, ~pat[3], pat[2:0]});
    checkAll("R2");
    setLatch(1'b0);
    for (int k = 0; k < 8; k++) begin
      serialBit(k[0]);
      checkAll("R3");
    end

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2, 3: begin
          parWrite(4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)));
          checkAll("R4");
        end
        4, 5: begin
          serialBit(1'($urandom_range(0, 1)));
          checkAll("R3");
        end
        6: begin setLatch(~mLatch); checkAll("R5"); end
        7: begin
          if (!mLatch) setEdge(1'($urandom_range(0, 1)));
          checkAll("R6");
        end
        8: begin parWrite(4'b1111, 3'($urandom_range(0, 7))); checkAll("R10"); end
        default: begin
          parWrite(4'($urandom_range(11, 14)), 3'($urandom_range(0, 7)));
          checkAll("R7");
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule